// File: doc/BRIEF.md
# Three-Wire Serial Control Register with Latch Select

This block takes 24-bit control words from a three-wire serial port (serial clock, serial data, load strobe) and moves each completed word into one of two parallel holding registers. All three serial lines are synchronized into the system clock domain. Bits enter a single shared shift register on each rising serial clock while the strobe is low. When the strobe rises, the last two bits received form a destination code. That code routes the rest of the word to the divider register, to the reference register, or to neither.

The divider register holds a 12-bit main count, a 5-bit swallow count and a 5-bit boost level. The reference register holds a 16-bit reference count, a lock-detect enable and two test bits. The block also presents the total division ratios implied by the held counts: 32 × main + swallow for the loop divider, and 4 × reference count for the reference path, which has a fixed divide-by-4 stage in front of it. A one-cycle pulse marks every load, with a separate pulse for each register. Downstream divider logic can pick up new settings on that pulse.

Top module: `ctl3w_top`

## Requirements
- R1: Word bit 1 is the first bit sent and bit 24 the last. A bit enters the shift register on each rising edge of `ser_clk` seen while `ser_le` is low.
- R2: When `ser_le` rises and bits 23,24 are 0,0, the divider register loads. Bits 1–12 go to `main_cnt` (bit 1 is its MSB), bits 13–17 to `swal_cnt` (bit 13 is its MSB) and bits 18–22 to `boost_lvl` (bit 18 is its MSB).
- R3: While `ser_le` is high, `ser_clk` and `ser_data` have no effect. The shift register keeps its contents.
- R4: When `ser_le` rises and bits 23,24 are 0,1, the reference register loads. Bits 1–16 go to `ref_cnt` (bit 1 is its MSB), bit 20 to `lock_det_en`, and bits 21,22 to `test_bits[1]`,`test_bits[0]`. Bits 17–19 are dropped.
- R5: When `ser_le` rises and bits 23,24 are 1,0 or 1,1, neither register changes and no load pulse is issued.
- R6: Each load raises `div_load` (divider register) or `ref_load` (reference register) for exactly one clock cycle. The two pulses are never high together.
- R7: Held values change only in the cycle their load pulse is high. Shifting bits in does not disturb them.
- R8: The shift register is not cleared between words and bits are not counted. A strobe after fewer than 24 bits loads the current shift register contents, which are the older bits moved up by the number of new bits.
- R9: `ref_div_total` always equals 4 × `ref_cnt`. A count of 144 gives 576.
- R10: `n_div_total` always equals 32 × `main_cnt` + `swal_cnt`.
- R11: Reset clears both registers to zero and holds both load pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge loads, high freezes the shift register |
| main_cnt | output | 12 | Main counter setting |
| swal_cnt | output | 5 | Swallow counter setting |
| boost_lvl | output | 5 | Fast-lock boost level |
| n_div_total | output | 17 | Loop divide ratio 32 × main + swallow |
| ref_cnt | output | 16 | Reference counter setting |
| lock_det_en | output | 1 | Lock-detect output enable |
| test_bits | output | 2 | Test field of the reference word |
| ref_div_total | output | 18 | Reference divide ratio 4 × ref_cnt |
| div_load | output | 1 | One-cycle pulse on divider register load |
| ref_load | output | 1 | One-cycle pulse on reference register load |

## Verification
The bench covers several hazards:
- Reserved destination codes 10 and 11. A decoder that tested only bit 24 would send those words into a register.
- Serial clocks sent during a high strobe, followed by a second strobe. A design that kept shifting would load the junk word instead of reloading the old one.
- A short 8-bit burst. This shows whether leftover bits from the previous word are kept or cleared.
- Extreme field values: all-ones counts, main count 32 and reference count 5. These catch field slices that are off by one bit.
- The known pair 144 → 576.

Counting pulses per strobe exposes a pulse held longer than one cycle, or a pulse raised on both registers.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int WORD_W       = 24;
  localparam int SEL_W        = 2;
  localparam int MAIN_W       = 12;
  localparam int SWAL_W       = 5;
  localparam int BOOST_W      = 5;
  localparam int REF_W        = 16;
  localparam int SPARE_W      = 3;
  localparam int TEST_W       = 2;
  localparam int DMP_SHIFT    = 5;   // dual-modulus prescaler = 2**DMP_SHIFT
  localparam int REFPRE_SHIFT = 2;   // fixed reference prescaler = 2**REFPRE_SHIFT
  localparam int PAY_W        = WORD_W - SEL_W;
  localparam int NTOT_W       = MAIN_W + DMP_SHIFT;
  localparam int RTOT_W       = REF_W + REFPRE_SHIFT;
  localparam int DIV_W        = MAIN_W + SWAL_W + BOOST_W;
  localparam int REFL_W       = REF_W + 1 + TEST_W;

  typedef enum logic [SEL_W-1:0] {
    DEST_DIV  = 2'b00,
    DEST_REF  = 2'b01,
    DEST_RSV2 = 2'b10,
    DEST_RSV3 = 2'b11
  } dest_e;

  typedef struct packed {
    logic [MAIN_W-1:0]  main_cnt;
    logic [SWAL_W-1:0]  swal_cnt;
    logic [BOOST_W-1:0] boost;
  } div_pay_t;

  typedef struct packed {
    logic [REF_W-1:0]   ref_cnt;
    logic [SPARE_W-1:0] spare;
    logic               lock_en;
    logic [TEST_W-1:0]  test;
  } ref_pay_t;

  // loop division: P*M + S with P a power of two
  function automatic logic [NTOT_W-1:0] n_total(input logic [MAIN_W-1:0] m,
                                                input logic [SWAL_W-1:0] s);
    logic [NTOT_W-1:0] scaled;
    scaled = {m, {DMP_SHIFT{1'b0}}};
    return scaled + NTOT_W'(s);
  endfunction

  // reference division: fixed prescaler times counter
  function automatic logic [RTOT_W-1:0] r_total(input logic [REF_W-1:0] r);
    return {r, {REFPRE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[g] <= '0;
          else        st[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/ctl3w_shreg.sv
module ctl3w_shreg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sle_s,
  output logic              shift_evt,
  output logic              le_rise,
  output logic [WORD_W-1:0] word
);
  logic sclk_q;
  logic sle_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sle_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sle_q  <= sle_s;
    end

  // serial clock edges count only while the strobe is low
  assign shift_evt = sclk_s & ~sclk_q & ~sle_s;
  assign le_rise   = sle_s & ~sle_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         word <= '0;
    else if (shift_evt) word <= {word[WORD_W-2:0], sdat_s};
endmodule

// File: rtl/ctl3w_field_latch.sv
module ctl3w_field_latch #(
  parameter int         W     = 8,
  parameter int         SEL_W = 2,
  parameter logic [1:0] CODE  = 2'b00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le_rise,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q,
  output logic             load
);
  logic hit;
  assign hit = le_rise && (sel == SEL_W'(CODE));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q    <= '0;
      load <= 1'b0;
    end else begin
      load <= hit;
      if (hit) q <= d;
    end
endmodule

// File: rtl/ctl3w_top.sv
module ctl3w_top
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic [BOOST_W-1:0] boost_lvl,
  output logic [NTOT_W-1:0] n_div_total,
  output logic [REF_W-1:0]  ref_cnt,
  output logic              lock_det_en,
  output logic [TEST_W-1:0] test_bits,
  output logic [RTOT_W-1:0] ref_div_total,
  output logic              div_load,
  output logic              ref_load
);
  logic [2:0]        ser_s;
  logic              le_s;
  logic              shift_evt;
  logic              le_rise;
  logic [WORD_W-1:0] sr_word;
  logic [SEL_W-1:0]  sel_code;
  div_pay_t          div_in;
  ref_pay_t          ref_in;
  logic [DIV_W-1:0]  div_q;
  logic [REFL_W-1:0] ref_q;

  ctl3w_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_clk, ser_data, ser_le}),
    .q(ser_s)
  );

  assign le_s = ser_s[0];

  ctl3w_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(ser_s[2]), .sdat_s(ser_s[1]), .sle_s(le_s),
    .shift_evt(shift_evt), .le_rise(le_rise), .word(sr_word)
  );

  // destination code sits in the last two bits received
  assign sel_code = sr_word[SEL_W-1:0];
  assign div_in   = div_pay_t'(sr_word[WORD_W-1:SEL_W]);
  assign ref_in   = ref_pay_t'(sr_word[WORD_W-1:SEL_W]);

  ctl3w_field_latch #(.W(DIV_W), .SEL_W(SEL_W), .CODE(DEST_DIV)) u_div_latch (
    .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .sel(sel_code),
    .d({div_in.main_cnt, div_in.swal_cnt, div_in.boost}),
    .q(div_q), .load(div_load)
  );

  ctl3w_field_latch #(.W(REFL_W), .SEL_W(SEL_W), .CODE(DEST_REF)) u_ref_latch (
    .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .sel(sel_code),
    .d({ref_in.ref_cnt, ref_in.lock_en, ref_in.test}),
    .q(ref_q), .load(ref_load)
  );

  assign {main_cnt, swal_cnt, boost_lvl}  = div_q;
  assign {ref_cnt, lock_det_en, test_bits} = ref_q;

  assign n_div_total   = n_total(main_cnt, swal_cnt);
  assign ref_div_total = r_total(ref_cnt);
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              le_s,
  input logic              shift_evt,
  input logic              le_rise,
  input logic [WORD_W-1:0] sr_word,
  input logic [SEL_W-1:0]  sel_code,
  input logic [MAIN_W-1:0] main_cnt,
  input logic [SWAL_W-1:0] swal_cnt,
  input logic [BOOST_W-1:0] boost_lvl,
  input logic [NTOT_W-1:0] n_div_total,
  input logic [REF_W-1:0]  ref_cnt,
  input logic              lock_det_en,
  input logic [TEST_W-1:0] test_bits,
  input logic [RTOT_W-1:0] ref_div_total,
  input logic              div_load,
  input logic              ref_load
);
  assert_shift_le_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> !le_s);
  assert_sr_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(sr_word));
  assert_div_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel_code == 2'b00) |=> div_load);
  assert_ref_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel_code == 2'b01) |=> ref_load);
  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel_code[1]) |=> (!div_load && !ref_load));
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_load, ref_load}));
  assert_div_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> !div_load);
  assert_ref_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load |=> !ref_load);
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !div_load |-> $stable({main_cnt, swal_cnt, boost_lvl}));
  assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_load |-> $stable({ref_cnt, lock_det_en, test_bits}));
  assert_rtot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_div_total == RTOT_W'(ref_cnt) * RTOT_W'(4));
  assert_ntot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    n_div_total == NTOT_W'(main_cnt) * NTOT_W'(32) + NTOT_W'(swal_cnt));
endmodule

bind ctl3w_top ctl3w_chk u_chk (.*);

// File: tb/ctl3w_top_bench.sv
module ctl3w_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b0;
  logic [11:0] main_cnt;
  logic [4:0]  swal_cnt;
  logic [4:0]  boost_lvl;
  logic [16:0] n_div_total;
  logic [15:0] ref_cnt;
  logic        lock_det_en;
  logic [1:0]  test_bits;
  logic [17:0] ref_div_total;
  logic        div_load;
  logic        ref_load;

  always #4 clk = ~clk;   // 125 MHz

  ctl3w_top u_ctl3w_top (.*);

  int vectors = 0;
  int miscompares = 0;
  int n_div_p = 0;
  int n_ref_p = 0;
  bit done = 1'b0;

  // bench model of the holding registers and the shift register
  int e_main = 0, e_swal = 0, e_boost = 0, e_ref = 0, e_lock = 0, e_test = 0;
  logic [23:0] m_sr = '0;

  // kind: 0 divider, 1 reference, 2 discard ; then the 24-bit word
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 12'd314,  5'd4,  5'd0,  2'b00},
    {2'd1, 16'd144,  3'b000, 1'b1, 2'b00, 2'b01},
    {2'd0, 12'd4095, 5'd31, 5'd31, 2'b00},
    {2'd1, 16'hFFFF, 3'b111, 1'b0, 2'b10, 2'b01},
    {2'd2, 22'h2AAAAA, 2'b10},
    {2'd2, 22'h155555, 2'b11},
    {2'd0, 12'd32,   5'd0,  5'd1,  2'b00},
    {2'd1, 16'd5,    3'b010, 1'b1, 2'b01, 2'b01}
  };

  always @(negedge clk) if (rst_n) begin
    if (div_load) n_div_p++;
    if (ref_load) n_ref_p++;
  end

  // bit n of a word, numbered 1..24 in send order
  function automatic int wbit(input logic [23:0] w, input int n);
    return int'(w[24-n]);
  endfunction

  function automatic int field(input logic [23:0] w, input int first, input int last);
    int v = 0;
    for (int n = first; n <= last; n++) v = v * 2 + wbit(w, n);
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      m_sr = {m_sr[22:0], w[i]};
    end
  endtask

  // strobe and update model from the current shift register image
  task automatic strobe(output int kind);
    int code;
    repeat (4) @(negedge clk); ser_le = 1'b1;
    repeat (12) @(negedge clk); ser_le = 1'b0;
    repeat (6) @(negedge clk);
    code = wbit(m_sr, 23) * 2 + wbit(m_sr, 24);
    kind = (code == 0) ? 0 : (code == 1) ? 1 : 2;
    if (kind == 0) begin
      e_main = field(m_sr, 1, 12); e_swal = field(m_sr, 13, 17); e_boost = field(m_sr, 18, 22);
    end else if (kind == 1) begin
      e_ref = field(m_sr, 1, 16); e_lock = wbit(m_sr, 20); e_test = field(m_sr, 21, 22);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 main"},  int'(main_cnt),  e_main);
    chk({tag, " R2 swal"},  int'(swal_cnt),  e_swal);
    chk({tag, " R2 boost"}, int'(boost_lvl), e_boost);
    chk({tag, " R4 ref"},   int'(ref_cnt),   e_ref);
    chk({tag, " R4 lock"},  int'(lock_det_en), e_lock);
    chk({tag, " R4 test"},  int'(test_bits), e_test);
    chk({tag, " R10 ntot"}, int'(n_div_total), e_main * 32 + e_swal);
    chk({tag, " R9 rtot"},  int'(ref_div_total), e_ref * 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int kind, d0, r0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 main", int'(main_cnt), 0);
    chk("R11 ref", int'(ref_cnt), 0);
    chk("R11 pulses", int'({div_load, ref_load}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 no pulse after release", n_div_p + n_ref_p, 0);

    // R1 R2 R4 R5 R6 table walk
    for (int v = 0; v < 8; v++) begin
      d0 = n_div_p; r0 = n_ref_p;
      send(VEC[v][23:0], 24);
      strobe(kind);
      chk("R5 kind from table", kind, int'(VEC[v][25:24]));
      check_all("R1 vec");
      chk("R6 div pulses", n_div_p - d0, (kind == 0) ? 1 : 0);
      chk("R6 ref pulses", n_ref_p - r0, (kind == 1) ? 1 : 0);
      if (v == 1) chk("R9 144 gives 576", int'(ref_div_total), 576);
    end

    // R7 shifting a full word without a strobe leaves outputs alone
    send({12'd77, 5'd3, 5'd9, 2'b00}, 24);
    check_all("R7 no strobe");
    // that word now loads
    d0 = n_div_p;
    strobe(kind);
    check_all("R7 then strobe");
    chk("R6 div pulse", n_div_p - d0, 1);

    // R3 clocks while the strobe is high are ignored
    send({16'd999, 3'b000, 1'b1, 2'b11, 2'b01}, 24);
    strobe(kind);
    check_all("R3 ref word");
    repeat (4) @(negedge clk); ser_le = 1'b1;
    begin
      logic [23:0] junk = {12'd5, 5'd5, 5'd5, 2'b00};
      for (int i = 23; i >= 0; i--) begin
        @(negedge clk); ser_data = junk[i];
        repeat (4) @(negedge clk); ser_clk = 1'b1;
        repeat (4) @(negedge clk); ser_clk = 1'b0;
      end
    end
    repeat (4) @(negedge clk); ser_le = 1'b0;
    repeat (6) @(negedge clk);
    d0 = n_div_p; r0 = n_ref_p;
    strobe(kind);   // model register untouched by the junk
    check_all("R3 after ignored clocks");
    chk("R3 reload goes to ref", n_ref_p - r0, 1);
    chk("R3 no div pulse", n_div_p - d0, 0);

    // R8 short burst: 8 bits appended to the old contents
    d0 = n_div_p; r0 = n_ref_p;
    send(24'h0000A4, 8);
    strobe(kind);
    check_all("R8 short word");
    chk("R8 div pulses", n_div_p - d0, (kind == 0) ? 1 : 0);
    chk("R8 ref pulses", n_ref_p - r0, (kind == 1) ? 1 : 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule